// File: doc/BRIEF.md
# DS3 Frame Alarm Integrator

This block sits behind a DS3 framer and turns that framer's per-frame indications into stable alarm status bits. For each received frame the framer pulses a frame strobe and presents four things: its out-of-frame state, the first C bit, and the two X bits. For each M-subframe it pulses a subframe strobe together with that subframe's three C bits. The block keeps a separate run counter for each alarm and changes an alarm's state only after the input condition has held for the required number of consecutive frames. The frame counts differ between setting and clearing an alarm.

Four status bits come out:
- loss of frame;
- first-C-bit detect;
- remote alarm indication detect;
- C-bit-all-zero detect.

Each status bit has a one-cycle change pulse beside it, so that a separate interrupt block can turn changes into events. The C-bit-all-zero alarm clears at subframe granularity: a single subframe whose C bits are all 1 clears it at once.

All inputs are sampled on the rising clock edge at which their strobe is high. A status bit that changes shows its new value, and its change pulse, in the cycle that follows that edge.

Top module: `ds3_alarm_integ`

## Requirements
- R1: After reset, all four status bits and all four change pulses are 0.
- R2: `lof` rises after `LOF_SET` consecutive frame strobes (default 28) sampled with `oof` high. A frame strobe sampled with `oof` low restarts the count.
- R3: Once `lof` is 1, it falls only after `LOF_CLR` consecutive frame strobes (default 28) sampled with `oof` low. A frame with `oof` high restarts the count.
- R4: `c1_det` rises after `C1_SET` consecutive frames (default 8) with `c1_bit` equal to 1. A frame with `c1_bit` equal to 0 restarts the count.
- R5: Once `c1_det` is 1, it falls only after `C1_CLR` consecutive frames (default 3) with `c1_bit` equal to 0. A frame with `c1_bit` equal to 1 restarts the count.
- R6: `rai_det` rises after `RAI_SET` consecutive frames (default 2) with `x_bits` equal to 2'b00. It falls after `RAI_CLR` consecutive frames (default 2) with `x_bits` equal to 2'b11. A frame with mixed X bits (2'b01 or 2'b10) restarts both runs.
- R7: `cbz_det` rises after `CBZ_SET` consecutive frames (default 3) in which every C bit was 0. A frame's C bits are those presented with `sub_stb` since the previous frame strobe, including a `sub_stb` in the same cycle as `frame_stb`. Any 1 among them restarts the count.
- R8: While `cbz_det` is 1, a `sub_stb` with `c_bits` equal to 3'b111 clears it in the following cycle, without waiting for the frame strobe.
- R9: `delta[0]`, `delta[1]`, `delta[2]` and `delta[3]` pulse high for exactly one cycle when `lof`, `c1_det`, `rai_det` and `cbz_det` change, respectively. Each pulse is high in the same cycle as the new status value.
- R10: In cycles without `frame_stb` or `sub_stb`, the data inputs are ignored. No status bit changes and the run counters hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per received DS3 frame |
| sub_stb | input | 1 | One-cycle pulse per M-subframe; `c_bits` is valid with it |
| oof | input | 1 | Framer out-of-frame state, sampled with `frame_stb` |
| c1_bit | input | 1 | First C bit of the frame, sampled with `frame_stb` |
| x_bits | input | 2 | Both X bits of the frame, sampled with `frame_stb` |
| c_bits | input | 3 | C bits of the current M-subframe |
| lof | output | 1 | Loss-of-frame status |
| c1_det | output | 1 | First-C-bit detect status |
| rai_det | output | 1 | Remote alarm indication detect status |
| cbz_det | output | 1 | C-bit-all-zero detect status |
| delta | output | 4 | Change pulses {cbz, rai, c1, lof} |

## Verification
The bench builds the block with its default thresholds: 28/28 frames for loss of frame, 8/3 for C1, 2/2 for RAI and 3 for the C-bit set run. Runs one frame short of a threshold therefore stay cheap, and the broken runs around them are easy to reach. With these values the bench can hit the exact frame where each alarm changes. It can also see that a single contrary frame, 27 frames into a loss-of-frame run, restarts the whole count. The short RAI and C-bit thresholds let the bench interleave mixed-X frames and a subframe-level clear within a few frames.

// File: rtl/ds3_alarm_integ.sv
module ds3_alarm_integ #(
  parameter int LOF_SET = 28,
  parameter int LOF_CLR = 28,
  parameter int C1_SET  = 8,
  parameter int C1_CLR  = 3,
  parameter int RAI_SET = 2,
  parameter int RAI_CLR = 2,
  parameter int CBZ_SET = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_stb,
  input  logic       sub_stb,
  input  logic       oof,
  input  logic       c1_bit,
  input  logic [1:0] x_bits,
  input  logic [2:0] c_bits,
  output logic       lof,
  output logic       c1_det,
  output logic       rai_det,
  output logic       cbz_det,
  output logic [3:0] delta
);

  localparam int LW = $clog2((LOF_SET > LOF_CLR ? LOF_SET : LOF_CLR) + 1);
  localparam int CW = $clog2((C1_SET > C1_CLR ? C1_SET : C1_CLR) + 1);
  localparam int RW = $clog2((RAI_SET > RAI_CLR ? RAI_SET : RAI_CLR) + 1);
  localparam int ZW = $clog2(CBZ_SET + 1);

  logic [LW-1:0] lof_cnt, lof_cnt_n;
  logic [CW-1:0] c1_cnt, c1_cnt_n;
  logic [RW-1:0] rai_cnt, rai_cnt_n;
  logic [ZW-1:0] cbz_cnt, cbz_cnt_n;
  logic          lof_n, c1_n, rai_n, cbz_n;
  logic          c_seen, c_seen_n;

  wire sub_one    = sub_stb & (|c_bits);
  wire frame_zero = ~(c_seen | sub_one);
  wire lof_hit    = lof ? ~oof : oof;
  wire c1_hit     = c1_det ? ~c1_bit : c1_bit;
  wire rai_hit    = rai_det ? (x_bits == 2'b11) : (x_bits == 2'b00);

  assign c_seen_n = frame_stb ? 1'b0 : (c_seen | sub_one);

  always_comb begin
    lof_n = lof;
    lof_cnt_n = lof_cnt;
    if (frame_stb) begin
      if (!lof_hit) lof_cnt_n = '0;
      else if (lof_cnt == LW'(lof ? LOF_CLR - 1 : LOF_SET - 1)) begin
        lof_n = ~lof;
        lof_cnt_n = '0;
      end else lof_cnt_n = lof_cnt + 1'b1;
    end
  end

  always_comb begin
    c1_n = c1_det;
    c1_cnt_n = c1_cnt;
    if (frame_stb) begin
      if (!c1_hit) c1_cnt_n = '0;
      else if (c1_cnt == CW'(c1_det ? C1_CLR - 1 : C1_SET - 1)) begin
        c1_n = ~c1_det;
        c1_cnt_n = '0;
      end else c1_cnt_n = c1_cnt + 1'b1;
    end
  end

  always_comb begin
    rai_n = rai_det;
    rai_cnt_n = rai_cnt;
    if (frame_stb) begin
      if (!rai_hit) rai_cnt_n = '0;
      else if (rai_cnt == RW'(rai_det ? RAI_CLR - 1 : RAI_SET - 1)) begin
        rai_n = ~rai_det;
        rai_cnt_n = '0;
      end else rai_cnt_n = rai_cnt + 1'b1;
    end
  end

  always_comb begin
    cbz_n = cbz_det;
    cbz_cnt_n = cbz_cnt;
    if (cbz_det) begin
      cbz_cnt_n = '0;
      if (sub_stb && (&c_bits)) cbz_n = 1'b0;
    end else if (frame_stb) begin
      if (!frame_zero) cbz_cnt_n = '0;
      else if (cbz_cnt == ZW'(CBZ_SET - 1)) begin
        cbz_n = 1'b1;
        cbz_cnt_n = '0;
      end else cbz_cnt_n = cbz_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {lof, c1_det, rai_det, cbz_det} <= '0;
      {lof_cnt, c1_cnt, rai_cnt, cbz_cnt} <= '0;
      c_seen <= 1'b0;
      delta <= '0;
    end else begin
      lof <= lof_n;
      c1_det <= c1_n;
      rai_det <= rai_n;
      cbz_det <= cbz_n;
      lof_cnt <= lof_cnt_n;
      c1_cnt <= c1_cnt_n;
      rai_cnt <= rai_cnt_n;
      cbz_cnt <= cbz_cnt_n;
      c_seen <= c_seen_n;
      delta <= {cbz_n, rai_n, c1_n, lof_n} ^ {cbz_det, rai_det, c1_det, lof};
    end
  end

endmodule

// File: rtl/ds3_alarm_integ_chk.sv
module ds3_alarm_integ_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic       sub_stb,
  input logic       oof,
  input logic       c1_bit,
  input logic [1:0] x_bits,
  input logic [2:0] c_bits,
  input logic       lof,
  input logic       c1_det,
  input logic       rai_det,
  input logic       cbz_det,
  input logic [3:0] delta
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |=> ({lof, c1_det, rai_det, cbz_det, delta} == '0));
  // R2
  lof_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(lof) |-> $past(frame_stb && oof));
  // R3
  lof_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(lof) |-> $past(frame_stb && !oof));
  // R4
  c1_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(c1_det) |-> $past(frame_stb && c1_bit));
  // R5
  c1_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(c1_det) |-> $past(frame_stb && !c1_bit));
  // R6
  rai_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rai_det) |-> $past(frame_stb && x_bits == 2'b00));
  // R6
  rai_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(rai_det) |-> $past(frame_stb && x_bits == 2'b11));
  // R7
  cbz_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cbz_det) |-> $past(frame_stb && (!sub_stb || c_bits == 3'b000)));
  // R8
  cbz_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cbz_det) |-> $past(sub_stb && c_bits == 3'b111));
  // R9
  delta_match_chk: assert property (@(posedge clk) disable iff (!rst_n) delta == ({cbz_det, rai_det, c1_det, lof} ^ $past({cbz_det, rai_det, c1_det, lof})));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(!frame_stb && !sub_stb) |-> $stable({cbz_det, rai_det, c1_det, lof}));

endmodule

bind ds3_alarm_integ ds3_alarm_integ_chk chk_i (.*);

// File: tb/ds3_alarm_integ_tb.sv
module ds3_alarm_integ_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_stb = 0, sub_stb = 0, oof = 0, c1_bit = 0;
  logic [1:0] x_bits = 0;
  logic [2:0] c_bits = 0;
  logic lof, c1_det, rai_det, cbz_det;
  logic [3:0] delta;

  int checks = 0, errors = 0;
  int dcnt [4] = '{0, 0, 0, 0};
  int dexp [4] = '{0, 0, 0, 0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  ds3_alarm_integ dut_i (.*);

  // row: count[23:16] oof[15] c1[14] x[13:12] cmode[11:10] exp{cbz,rai,c1,lof}[3:0]
  localparam logic [23:0] TBL [22] = '{
    {8'd27, 1'b1, 1'b1, 2'b00, 2'd0, 6'd0, 4'b1110},
    {8'd1,  1'b1, 1'b1, 2'b00, 2'd0, 6'd0, 4'b1111},
    {8'd27, 1'b0, 1'b0, 2'b11, 2'd1, 6'd0, 4'b1001},
    {8'd1,  1'b0, 1'b0, 2'b01, 2'd2, 6'd0, 4'b0000},
    {8'd7,  1'b0, 1'b1, 2'b00, 2'd0, 6'd0, 4'b1100},
    {8'd1,  1'b0, 1'b0, 2'b10, 2'd0, 6'd0, 4'b1100},
    {8'd1,  1'b0, 1'b1, 2'b11, 2'd0, 6'd0, 4'b1100},
    {8'd1,  1'b0, 1'b1, 2'b01, 2'd0, 6'd0, 4'b1100},
    {8'd1,  1'b0, 1'b1, 2'b11, 2'd0, 6'd0, 4'b1100},
    {8'd5,  1'b0, 1'b1, 2'b11, 2'd0, 6'd0, 4'b1010},
    {8'd2,  1'b0, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1110},
    {8'd1,  1'b0, 1'b1, 2'b00, 2'd0, 6'd0, 4'b1110},
    {8'd2,  1'b0, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1110},
    {8'd1,  1'b0, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1100},
    {8'd27, 1'b1, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1100},
    {8'd1,  1'b0, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1100},
    {8'd27, 1'b1, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1100},
    {8'd1,  1'b1, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1101},
    {8'd27, 1'b0, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1101},
    {8'd1,  1'b1, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1101},
    {8'd27, 1'b0, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1101},
    {8'd1,  1'b0, 1'b0, 2'b00, 2'd0, 6'd0, 4'b1100}
  };

  always @(negedge clk)
    if (rst_n)
      for (int i = 0; i < 4; i++) if (delta[i]) dcnt[i]++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic o, input logic c1, input logic [1:0] x, input int cm);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      frame_stb = (s == 6); sub_stb = 1'b1; oof = o; c1_bit = c1; x_bits = x;
      case (cm)
        0: c_bits = 3'b000;
        1: c_bits = 3'b010;
        2: c_bits = (s == 3) ? 3'b111 : 3'b000;
        default: c_bits = (s == 6) ? 3'b001 : 3'b000;
      endcase
    end
    @(negedge clk);
    frame_stb = 0; sub_stb = 0; oof = ~o; c1_bit = ~c1; x_bits = ~x; c_bits = 3'b111;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] prev, st;
    repeat (3) @(negedge clk);
    // R1
    check({lof, c1_det, rai_det, cbz_det, delta} == '0, "R1 reset state", {lof, c1_det, rai_det, cbz_det, delta}, 0);
    rst_n = 1'b1;
    prev = 4'b0000;

    for (int r = 0; r < 22; r++) begin
      for (int f = 0; f < int'(TBL[r][23:16]); f++)
        send_frame(TBL[r][15], TBL[r][14], TBL[r][13:12], int'(TBL[r][11:10]));
      for (int b = 0; b < 4; b++) if (TBL[r][b] != prev[b]) dexp[b]++;
      prev = TBL[r][3:0];
      check(lof == TBL[r][0], $sformatf("R2/R3 lof row %0d", r), lof, TBL[r][0]);
      check(c1_det == TBL[r][1], $sformatf("R4/R5 c1_det row %0d", r), c1_det, TBL[r][1]);
      check(rai_det == TBL[r][2], $sformatf("R6 rai_det row %0d", r), rai_det, TBL[r][2]);
      check(cbz_det == TBL[r][3], $sformatf("R7/R8 cbz_det row %0d", r), cbz_det, TBL[r][3]);
    end
    @(negedge clk); #1;
    for (int b = 0; b < 4; b++)
      check(dcnt[b] == dexp[b], $sformatf("R9 delta[%0d] pulse count", b), dcnt[b], dexp[b]);

    // R8: clear inside a frame, without frame strobe
    @(negedge clk); sub_stb = 1; c_bits = 3'b000;
    @(negedge clk); sub_stb = 1; c_bits = 3'b111;
    @(negedge clk); sub_stb = 0; c_bits = 3'b000;
    check(cbz_det == 1'b0, "R8 mid-frame clear", cbz_det, 0);
    // R9
    check(delta == 4'b1000, "R9 cbz pulse same cycle", delta, 4'b1000);
    @(negedge clk);
    check(delta == 4'b0000, "R9 pulse lasts one cycle", delta, 0);
    frame_stb = 1; sub_stb = 1;
    @(negedge clk); frame_stb = 0; sub_stb = 0;

    // R7: a 1 in the subframe coinciding with the frame strobe breaks the run
    send_frame(0, 0, 2'b00, 0);
    send_frame(0, 0, 2'b00, 0);
    send_frame(0, 0, 2'b00, 3);
    check(cbz_det == 1'b0, "R7 last-subframe one blocks set", cbz_det, 0);
    send_frame(0, 0, 2'b00, 0);
    send_frame(0, 0, 2'b00, 0);
    check(cbz_det == 1'b0, "R7 run restarted", cbz_det, 0);
    send_frame(0, 0, 2'b00, 0);
    check(cbz_det == 1'b1, "R7 set after three zero frames", cbz_det, 1);

    // R10: noisy inputs without strobes
    st = {cbz_det, rai_det, c1_det, lof};
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      oof = i[0]; c1_bit = i[1]; x_bits = i[2:1]; c_bits = 3'b111;
      check(delta == 4'b0000, "R10 no pulse without strobe", delta, 0);
    end
    @(negedge clk);
    check({cbz_det, rai_det, c1_det, lof} == st, "R10 status held", {cbz_det, rai_det, c1_det, lof}, st);
    // R10: rai run counter held; one 11 frame before idle, one after -> clear
    send_frame(0, 0, 2'b11, 0);
    repeat (10) @(negedge clk);
    send_frame(0, 0, 2'b11, 0);
    check(rai_det == 1'b0, "R10/R6 counter held across idle", rai_det, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule